// File: doc/BRIEF.md
# Retriggerable One-Shot Down Timer

A 16-bit one-shot pulse generator. Software loads a reload value and sets a run bit. A trigger, either a register write or a rising edge on an external pin, arms the timer. The output pulse goes high at the next count-source enable. The counter then steps down once per enable. When the counter is at zero and an enable arrives, the pulse drops, the counter reloads, and a sticky interrupt request flag is raised.

The count source comes from a prescaler outside the block, as a one-cycle enable input. The block is reached over a small register bus with a registered read path. Three situations get special treatment:
- A trigger that arrives mid-pulse stretches the pulse: one more decrement happens, then a reload.
- Clearing the run bit aborts the pulse and raises the flag a cycle later.
- A counter read that lands on a reload returns all ones.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the pulse output and the flag are 0 and the control register (address 0) reads 0. While the run bit (bit 0) is 0 the pulse output stays low.
- R2: The trigger select (bit 1) and the mode field (bits 3:2; 00 timer, 01 event, 10 one-shot, 11 PWM) change only on a control write made while the run bit is 0. Writes made while running leave them unchanged.
- R3: A write to address 1 while stopped sets both the reload value and the counter, and a read of address 1 then returns the written value. The same write while running changes only the reload value, and the counter keeps counting.
- R4: In one-shot mode with run set, an accepted trigger drives the pulse high at the next count enable. The counter starts from the reload value R and the pulse stays high for exactly R+1 count enables. The last of these finds the counter at 0: it drops the pulse, reloads the counter and sets the flag.
- R5: A software trigger is control bit 4 written as 1 together with run=1. It counts only when the run bit is already 1 and trigger select is 0. The external trigger is a rising edge on the pin, passed through a two-flop synchronizer, and counts only when trigger select is 1.
- R6: A trigger accepted while the pulse is high causes one more decrement at the next count enable and a reload at the one after, and the pulse stays high. Further triggers are ignored until that reload has happened.
- R7: A control write that clears the run bit while it is 1 does three things: the pulse is low after that clock edge, the counter is reloaded, and the flag is set one cycle later.
- R8: A read of address 1 in the same cycle as a reload (underflow, retrigger reload or stop) returns 16'hFFFF.
- R9: Writing mode 10 while stopped, from mode 00 or 01, sets the flag. Entering mode 10 from mode 11 does not.
- R10: The flag is read at address 2, bit 0. Writing 1 to that bit clears it and writing 0 leaves it unchanged. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; data valid the next cycle |
| regAddr | input | 2 | Register address: 0 control, 1 reload/counter, 2 flag |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Registered read data |
| cntEn | input | 1 | Count-source enable, one cycle per count |
| trigPin | input | 1 | External trigger pin, asynchronous |
| pulseOut | output | 1 | One-shot pulse output |
| irqFlag | output | 1 | Interrupt request flag |

## Verification
Pulse length is measured against the reload value using random reload values and random gaps between count enables. This separates a correct R+1 length from off-by-one errors in the start and underflow steps. Directed sequences cover the rest:
- A retrigger followed by a duplicate trigger, which shows whether the extra decrement happens and whether the second trigger is dropped.
- A read issued in the same cycle as an underflow.
- A stop in mid-pulse, which shows the one-cycle flag delay.
- A walk through the mode transitions, which shows which entries into one-shot mode raise the flag.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER   = 2'b00,
    MODE_EVENT   = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_PWM     = 2'b11
  } modeSel_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_FLAG  = 2'd2;

  localparam int BIT_RUN  = 0;
  localparam int BIT_TSEL = 1;
  localparam int BIT_MODE = 2;
  localparam int BIT_SWT  = 4;
  localparam int CTRL_W   = 5;

  typedef struct packed {
    logic wrReload;
    logic loadFromBus;
    logic loadFromReload;
    logic reloadEvt;
    logic decrement;
    logic readCount;
  } dpStrobe_t;

endpackage

// File: rtl/oneshot_datapath.sv
module oneshot_datapath
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [WIDTH-1:0] wdata,
  output logic             cntZero,
  output logic [WIDTH-1:0] rdCount
);

  logic [WIDTH-1:0] reloadQ;
  logic [WIDTH-1:0] countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (stb.wrReload) begin
      reloadQ <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (stb.loadFromBus) begin
      countQ <= wdata;
    end else if (stb.loadFromReload) begin
      countQ <= reloadQ;
    end else if (stb.decrement) begin
      countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCount <= '0;
    end else if (stb.readCount) begin
      rdCount <= stb.reloadEvt ? '1 : countQ;
    end
  end

  assign cntZero = (countQ == '0);

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [CTRL_W-1:0] wdataLo,
  input  logic              cntEn,
  input  logic              trigPin,
  input  logic              cntZero,
  output dpStrobe_t         stb,
  output logic              pulseOut,
  output logic              irqFlag,
  output logic              runBit,
  output logic [1:0]        modeBits,
  output logic [WIDTH-1:0]  rdCtrl,
  output logic              rdSelCount
);

  localparam int PAD_W = WIDTH - 4;

  logic       runQ, trigSelQ, countingQ, trigPendQ, reloadPendQ, stopDlyQ, flagQ;
  modeSel_t   modeQ;
  logic [SYNC_STAGES:0] syncQ;

  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= trigPin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic extEdge, wrCtrl, wrCount, wrFlag, active, stopEvt, swHit, extHit;
  logic trigAccept, tick, startEvt, underflow, retrigLoad, decEvt, modeEntry;

  always_comb begin
    extEdge    = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
    wrCtrl     = regWr && (regAddr == ADDR_CTRL);
    wrCount    = regWr && (regAddr == ADDR_COUNT);
    wrFlag     = regWr && (regAddr == ADDR_FLAG);
    active     = runQ && (modeQ == MODE_ONESHOT);
    stopEvt    = wrCtrl && runQ && !wdataLo[BIT_RUN];
    swHit      = wrCtrl && wdataLo[BIT_SWT] && wdataLo[BIT_RUN] && !trigSelQ;
    extHit     = trigSelQ && extEdge;
    trigAccept = active && !stopEvt && (swHit || extHit) && !trigPendQ && !reloadPendQ;
    tick       = active && !stopEvt && cntEn;
    startEvt   = tick && !countingQ && trigPendQ;
    retrigLoad = tick && countingQ && reloadPendQ;
    underflow  = tick && countingQ && !reloadPendQ && cntZero;
    decEvt     = tick && countingQ && !reloadPendQ && !cntZero;
    modeEntry  = wrCtrl && !runQ
                 && (wdataLo[BIT_MODE+1:BIT_MODE] == MODE_ONESHOT)
                 && ((modeQ == MODE_TIMER) || (modeQ == MODE_EVENT));

    stb.wrReload       = wrCount;
    stb.loadFromBus    = wrCount && !runQ;
    stb.loadFromReload = startEvt || underflow || retrigLoad || stopEvt;
    stb.reloadEvt      = underflow || retrigLoad || stopEvt;
    stb.decrement      = decEvt;
    stb.readCount      = regRd && (regAddr == ADDR_COUNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      trigSelQ <= 1'b0;
      modeQ    <= MODE_TIMER;
    end else if (wrCtrl) begin
      runQ <= wdataLo[BIT_RUN];
      if (!runQ) begin
        trigSelQ <= wdataLo[BIT_TSEL];
        modeQ    <= modeSel_t'(wdataLo[BIT_MODE+1:BIT_MODE]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countingQ   <= 1'b0;
      trigPendQ   <= 1'b0;
      reloadPendQ <= 1'b0;
      stopDlyQ    <= 1'b0;
    end else begin
      stopDlyQ <= stopEvt;
      if (stopEvt || underflow) countingQ <= 1'b0;
      else if (startEvt)        countingQ <= 1'b1;

      if (stopEvt || underflow)                      trigPendQ <= 1'b0;
      else if (trigAccept)                           trigPendQ <= 1'b1;
      else if (startEvt || (decEvt && trigPendQ))    trigPendQ <= 1'b0;

      if (stopEvt || underflow)        reloadPendQ <= 1'b0;
      else if (decEvt && trigPendQ)    reloadPendQ <= 1'b1;
      else if (retrigLoad)             reloadPendQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (underflow || stopDlyQ || modeEntry) begin
      flagQ <= 1'b1;
    end else if (wrFlag && wdataLo[0]) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCtrl     <= '0;
      rdSelCount <= 1'b0;
    end else if (regRd) begin
      rdSelCount <= (regAddr == ADDR_COUNT);
      if (regAddr == ADDR_CTRL)      rdCtrl <= {{PAD_W{1'b0}}, modeQ, trigSelQ, runQ};
      else if (regAddr == ADDR_FLAG) rdCtrl <= {{(WIDTH-1){1'b0}}, flagQ};
      else                           rdCtrl <= '0;
    end
  end

  assign pulseOut = countingQ;
  assign irqFlag  = flagQ;
  assign runBit   = runQ;
  assign modeBits = modeQ;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [1:0]       regAddr,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  input  logic             cntEn,
  input  logic             trigPin,
  output logic             pulseOut,
  output logic             irqFlag
);

  dpStrobe_t        dpStb;
  logic             cntZero, runBit, rdSelCount;
  logic [1:0]       modeBits;
  logic [WIDTH-1:0] rdCtrl, rdCount;

  oneshot_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wdataLo(regWdata[CTRL_W-1:0]), .cntEn(cntEn), .trigPin(trigPin),
    .cntZero(cntZero), .stb(dpStb), .pulseOut(pulseOut), .irqFlag(irqFlag),
    .runBit(runBit), .modeBits(modeBits), .rdCtrl(rdCtrl), .rdSelCount(rdSelCount)
  );

  oneshot_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(dpStb), .wdata(regWdata),
    .cntZero(cntZero), .rdCount(rdCount)
  );

  assign regRdata = rdSelCount ? rdCount : rdCtrl;

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic             regRd,
  input logic [1:0]       regAddr,
  input logic [WIDTH-1:0] regWdata,
  input logic [WIDTH-1:0] regRdata,
  input logic             pulseOut,
  input logic             irqFlag,
  input logic             runBit,
  input logic [1:0]       modeBits,
  input logic             reloadEvt
);

  logic stopWr;
  assign stopWr = regWr && (regAddr == 2'd0) && !regWdata[0] && runBit;

  // R1: no pulse while stopped
  a_r1_no_pulse_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !pulseOut);

  // R2: mode frozen while running
  a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rstN)
    runBit |=> $stable(modeBits));

  // R4: a pulse that ends without a stop leaves the flag set
  a_r4_end_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pulseOut) && !$past(stopWr)) |-> irqFlag);

  // R7: stop drops the pulse at once
  a_r7_stop_drops_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> !pulseOut);

  // R7: stop raises the flag one cycle later
  a_r7_stop_flag_late: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> ##1 irqFlag);

  // R8: read during reload returns all ones
  a_r8_read_on_reload: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 2'd1 && reloadEvt) |=> (regRdata == '1));

endmodule

bind oneshot_timer oneshot_timer_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .pulseOut(pulseOut), .irqFlag(irqFlag),
  .runBit(runBit), .modeBits(modeBits), .reloadEvt(dpStb.reloadEvt)
);

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWr = 1'b0, regRd = 1'b0;
  logic [1:0]   regAddr = '0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic         cntEn = 1'b0, trigPin = 1'b0;
  logic         pulseOut, irqFlag;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  oneshot_timer i_oneshot_timer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cntEn(cntEn), .trigPin(trigPin),
    .pulseOut(pulseOut), .irqFlag(irqFlag)
  );

  function automatic logic [W-1:0] ctrlWord(bit run, bit sel, logic [1:0] mode, bit sw);
    return W'({sw, mode, sel, run});
  endfunction

  function automatic int expPulse(int reloadVal);
    return reloadVal + 1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic cnt();
    cntEn = 1'b1;
    @(negedge clk);
    cntEn = 1'b0;
  endtask

  task automatic drain(int maxGap, output int n);
    n = 0;
    while (pulseOut && n < 200) begin
      tk($urandom_range(0, maxGap));
      cnt();
      n++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    int n;
    void'($urandom(32'h1234abcd));
    tk(3);
    rstN = 1'b1;
    tk(1);

    // R1 reset state
    check("R1 pulse after reset", pulseOut, 0);
    check("R1 flag after reset", irqFlag, 0);
    rd(2'd0, d); check("R1 ctrl after reset", d, 0);

    // R9 mode entry flag
    wr(2'd0, ctrlWord(0, 0, 2'b11, 0));
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0));
    check("R9 entry from PWM no flag", irqFlag, 0);
    wr(2'd0, ctrlWord(0, 0, 2'b01, 0));
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0));
    check("R9 entry from event sets flag", irqFlag, 1);
    wr(2'd2, 16'h0000);
    check("R10 write zero keeps flag", irqFlag, 1);
    wr(2'd2, 16'h0001);
    check("R10 write one clears flag", irqFlag, 0);
    wr(2'd0, ctrlWord(0, 0, 2'b00, 0));
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0));
    check("R9 entry from timer sets flag", irqFlag, 1);
    wr(2'd2, 16'h0001);

    // R3 reload write while stopped
    wr(2'd1, 16'd5);
    rd(2'd1, d); check("R3 stopped write reads back", d, 5);

    // R5 software trigger ignored while stopped
    wr(2'd0, ctrlWord(0, 0, 2'b10, 1));
    cnt(); cnt();
    check("R5 sw trigger ignored when stopped", pulseOut, 0);

    // R2 settings locked while running
    wr(2'd0, ctrlWord(1, 0, 2'b10, 0));
    wr(2'd0, ctrlWord(1, 1, 2'b00, 0));
    rd(2'd0, d); check("R2 mode locked while running", d, ctrlWord(1, 0, 2'b10, 0));

    // R4 basic one-shot with reload 3
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0)); tk(1); wr(2'd2, 16'h0001);
    wr(2'd1, 16'd3);
    wr(2'd0, ctrlWord(1, 0, 2'b10, 0));
    wr(2'd0, ctrlWord(1, 0, 2'b10, 1));
    check("R4 pulse waits for count source", pulseOut, 0);
    cnt();
    check("R4 pulse high after first enable", pulseOut, 1);
    cnt();
    wr(2'd1, 16'd9);
    rd(2'd1, d); check("R3 running write keeps counter", d, 2);
    drain(0, n);
    check("R4 remaining enables after reload write", n, 3);
    check("R4 underflow sets flag", irqFlag, 1);
    rd(2'd1, d); check("R3 new reload used after underflow", d, 9);
    wr(2'd2, 16'h0001);

    // R6 retrigger with reload 4
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0)); tk(1); wr(2'd2, 16'h0001);
    wr(2'd1, 16'd4);
    wr(2'd0, ctrlWord(1, 0, 2'b10, 0));
    wr(2'd0, ctrlWord(1, 0, 2'b10, 1));
    cnt(); cnt(); cnt();
    wr(2'd0, ctrlWord(1, 0, 2'b10, 1));
    wr(2'd0, ctrlWord(1, 0, 2'b10, 1));
    cnt();
    rd(2'd1, d); check("R6 one more decrement", d, 1);
    cnt();
    rd(2'd1, d); check("R6 reload after decrement", d, 4);
    check("R6 pulse stays high", pulseOut, 1);
    drain(1, n);
    check("R6 second trigger ignored", n, expPulse(4));

    // R8 read coinciding with underflow reload
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0)); tk(1); wr(2'd2, 16'h0001);
    wr(2'd1, 16'd2);
    wr(2'd0, ctrlWord(1, 0, 2'b10, 0));
    wr(2'd0, ctrlWord(1, 0, 2'b10, 1));
    cnt(); cnt(); cnt();
    regRd = 1'b1; regAddr = 2'd1; cntEn = 1'b1;
    @(negedge clk);
    regRd = 1'b0; cntEn = 1'b0;
    check("R8 read on reload", regRdata, 16'hFFFF);
    check("R4 pulse low after underflow", pulseOut, 0);
    rd(2'd1, d); check("R8 later read sees reload", d, 2);
    wr(2'd2, 16'h0001);

    // R7 stop mid-pulse
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0)); tk(1); wr(2'd2, 16'h0001);
    wr(2'd1, 16'd6);
    wr(2'd0, ctrlWord(1, 0, 2'b10, 0));
    wr(2'd0, ctrlWord(1, 0, 2'b10, 1));
    cnt(); cnt(); cnt();
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0));
    check("R7 pulse low after stop", pulseOut, 0);
    check("R7 flag not yet set", irqFlag, 0);
    tk(1);
    check("R7 flag one cycle later", irqFlag, 1);
    rd(2'd1, d); check("R7 counter reloaded", d, 6);
    cnt();
    check("R1 stays low when stopped", pulseOut, 0);
    wr(2'd2, 16'h0001);

    // R5 external trigger
    wr(2'd1, 16'd2);
    wr(2'd0, ctrlWord(0, 1, 2'b10, 0));
    wr(2'd0, ctrlWord(1, 1, 2'b10, 0));
    wr(2'd0, ctrlWord(1, 1, 2'b10, 1));
    cnt();
    check("R5 sw trigger ignored with pin select", pulseOut, 0);
    trigPin = 1'b1;
    tk(3);
    check("R5 pin not yet counted", pulseOut, 0);
    cnt();
    check("R5 pin edge starts pulse", pulseOut, 1);
    drain(0, n);
    check("R5 pin pulse length", n, expPulse(2));
    cnt();
    check("R5 held pin level no retrigger", pulseOut, 0);
    trigPin = 1'b0;
    wr(2'd0, ctrlWord(0, 1, 2'b10, 0)); tk(1); wr(2'd2, 16'h0001);
    wr(2'd0, ctrlWord(0, 0, 2'b10, 0));

    // R4 random reload values and enable gaps
    for (int it = 0; it < 24; it++) begin
      int rv;
      rv = $urandom_range(0, 9);
      wr(2'd1, W'(rv));
      wr(2'd0, ctrlWord(1, 0, 2'b10, 0));
      wr(2'd0, ctrlWord(1, 0, 2'b10, 1));
      tk($urandom_range(0, 3));
      cnt();
      drain(3, n);
      check("R4 random pulse length", n, expPulse(rv));
      check("R4 random flag", irqFlag, 1);
      wr(2'd0, ctrlWord(0, 0, 2'b10, 0));
      tk(1);
      wr(2'd2, 16'h0001);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule